// File: doc/BRIEF.md
# Received Pause Frame Detector

The detector watches the receive side of a 64-bit MAC datapath after the preamble and start delimiter have been removed. Each beat carries eight bytes. Start, end and valid markers mark the frame edges. The block parses the first three data beats of every frame. From them it decides whether the frame is a flow-control pause request meant for this station. When the frame closes cleanly, it reports the requested pause quanta to a downstream pause timer as a single-cycle pulse. It never stalls, drops or changes traffic. It only reports.

A frame is accepted only when four conditions all hold:
- The receive-pause enable is set when the frame starts.
- The destination matches the reserved flow-control multicast address, or the station's own address when unicast matching is switched on.
- The length/type field and the control opcode both identify a pause request.
- The CRC checker flags the frame as good on its last beat.

A finite state machine tracks the beat position. Its states are `ST_IDLE` (between frames), `ST_HDR` (destination accepted, waiting for the type/opcode beat), `ST_QNT` (header accepted, waiting for the quanta beat), `ST_TAIL` (quanta captured, waiting for the end) and `ST_SKIP` (frame rejected, waiting for its end). The transitions are:
- Start beat: to `ST_HDR` on an address hit with pause enabled, to `ST_SKIP` on a miss, and back to `ST_IDLE` if the same beat also ends the frame.
- Header beat: to `ST_QNT` on a pause type/opcode, to `ST_SKIP` otherwise, and to `ST_IDLE` on an early end.
- Quanta beat: to `ST_TAIL`, or to `ST_IDLE` with a report if it is also the end beat.
- Tail end beat: `ST_TAIL` to `ST_IDLE` with a report.
- Skip end beat: `ST_SKIP` to `ST_IDLE`.
- A start beat in any state abandons the current frame and re-enters the start-beat decision.

Top module: `rx_pause_detect`

## Requirements
- R1: After reset, `pause_valid` is 0 and `pause_quanta` is 0.
- R2: Byte 0 of a beat sits on bits [63:56]. On the start beat, bits [63:16] hold the destination address. On the second beat, bits [31:16] hold the type, which must be 0x8808, and bits [15:0] hold the opcode, which must be 0x0001. On the third beat, bits [63:48] hold the quanta with the first received byte as the most significant byte.
- R3: A report is a single-cycle high on `pause_valid` in the clock cycle after the end beat. `pause_quanta` carries the value and holds it until the next report.
- R4: A destination equal to 0x0180C2000001 is accepted. Any other address that is not the enabled station address gives no report.
- R5: A destination equal to `cfg_station_addr` is accepted only while `cfg_ucast_en` is 1 at the start beat.
- R6: With `cfg_rx_pause_en` at 0 on the start beat, the frame gives no report.
- R7: A wrong type or a wrong opcode gives no report.
- R8: With `rx_crc_ok` at 0 on the end beat, the frame gives no report.
- R9: A frame that ends before its third beat gives no report. A frame that ends exactly on the third beat is reported.
- R10: Cycles with `rx_valid` at 0 are ignored, so idle gaps inside a frame do not disturb parsing.
- R11: A start beat inside an unfinished frame abandons that frame and begins parsing a new one.
- R12: A quanta of zero (a resume request) is reported like any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Beat qualifier |
| rx_sop | input | 1 | First beat of a frame |
| rx_eop | input | 1 | Last beat of a frame |
| rx_data | input | 64 | Beat data, byte 0 at [63:56] |
| rx_crc_ok | input | 1 | CRC good, meaningful on the end beat |
| cfg_rx_pause_en | input | 1 | Receive-pause enable |
| cfg_ucast_en | input | 1 | Accept pause frames sent to the station address |
| cfg_station_addr | input | 48 | This station's unicast address |
| pause_valid | output | 1 | One-cycle report pulse |
| pause_quanta | output | 16 | Reported quanta, held between reports |

## Verification
The assertions assume the following about the inputs:
- `rx_sop`, `rx_eop` and `rx_crc_ok` mean something only on cycles with `rx_valid` at 1.
- The configuration inputs do not change in the middle of a frame.

The driver task keeps to these rules. It raises markers only together with `rx_valid`, and it changes configuration only between frames. It also leaves idle cycles between frames, so reports from back-to-back frames never merge. The scoreboard checks that every report arrives exactly when expected, and it treats any unexpected report as a failure.

// File: rtl/rxpause_pkg.sv
package rxpause_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_QNT,
        ST_TAIL,
        ST_SKIP
    } rxp_state_e;

    localparam logic [47:0] CTRL_MCAST_ADDR = 48'h0180_C200_0001;
    localparam logic [15:0] MAC_CTRL_TYPE   = 16'h8808;
    localparam logic [15:0] PAUSE_OPCODE    = 16'h0001;

endpackage

// File: rtl/rxp_addr_match.sv
module rxp_addr_match #(
    parameter int ADDR_W = 48
) (
    input  logic [ADDR_W-1:0] dest_addr,
    input  logic [ADDR_W-1:0] mcast_addr,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic              ucast_en,
    output logic              addr_hit
);

    logic mcast_hit;
    logic ucast_hit;

    always_comb begin
        mcast_hit = (dest_addr == mcast_addr);
        ucast_hit = ucast_en && (dest_addr == station_addr);
        addr_hit  = mcast_hit || ucast_hit;
    end

endmodule

// File: rtl/rxp_ctrl_decode.sv
module rxp_ctrl_decode #(
    parameter int FIELD_W = 16
) (
    input  logic [2*FIELD_W-1:0] type_op,
    input  logic [FIELD_W-1:0]   exp_type,
    input  logic [FIELD_W-1:0]   exp_opcode,
    output logic                 is_pause
);

    logic type_ok;
    logic op_ok;

    always_comb begin
        type_ok  = (type_op[2*FIELD_W-1:FIELD_W] == exp_type);
        op_ok    = (type_op[FIELD_W-1:0] == exp_opcode);
        is_pause = type_ok && op_ok;
    end

endmodule

// File: rtl/rx_pause_detect.sv
module rx_pause_detect
    import rxpause_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int ADDR_W   = 48,
    parameter int QUANTA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_valid,
    input  logic                rx_sop,
    input  logic                rx_eop,
    input  logic [DATA_W-1:0]   rx_data,
    input  logic                rx_crc_ok,
    input  logic                cfg_rx_pause_en,
    input  logic                cfg_ucast_en,
    input  logic [ADDR_W-1:0]   cfg_station_addr,
    output logic                pause_valid,
    output logic [QUANTA_W-1:0] pause_quanta
);

    // Field placement inside the beats (byte 0 on the top lane).
    localparam int DA_LSB  = DATA_W - ADDR_W;
    localparam int TO_W    = 2 * QUANTA_W;
    localparam int QNT_LSB = DATA_W - QUANTA_W;

    rxp_state_e state_q, state_d;
    logic [QUANTA_W-1:0] qnt_q;
    logic                addr_hit;
    logic                hdr_is_pause;
    logic                fire;
    logic [QUANTA_W-1:0] fire_qnt;

    rxp_addr_match #(.ADDR_W(ADDR_W)) u_addr (
        .dest_addr    (rx_data[DATA_W-1:DA_LSB]),
        .mcast_addr   (CTRL_MCAST_ADDR[ADDR_W-1:0]),
        .station_addr (cfg_station_addr),
        .ucast_en     (cfg_ucast_en),
        .addr_hit     (addr_hit)
    );

    rxp_ctrl_decode #(.FIELD_W(QUANTA_W)) u_ctrl (
        .type_op    (rx_data[TO_W-1:0]),
        .exp_type   (MAC_CTRL_TYPE[QUANTA_W-1:0]),
        .exp_opcode (PAUSE_OPCODE[QUANTA_W-1:0]),
        .is_pause   (hdr_is_pause)
    );

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        if (rx_valid) begin
            if (rx_sop) begin
                if (rx_eop)
                    state_d = ST_IDLE;
                else if (addr_hit && cfg_rx_pause_en)
                    state_d = ST_HDR;
                else
                    state_d = ST_SKIP;
            end else begin
                unique case (state_q)
                    ST_IDLE: state_d = ST_IDLE;
                    ST_HDR:  state_d = rx_eop ? ST_IDLE :
                                       (hdr_is_pause ? ST_QNT : ST_SKIP);
                    ST_QNT:  state_d = rx_eop ? ST_IDLE : ST_TAIL;
                    ST_TAIL: state_d = rx_eop ? ST_IDLE : ST_TAIL;
                    ST_SKIP: state_d = rx_eop ? ST_IDLE : ST_SKIP;
                    default: state_d = ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        fire = rx_valid && !rx_sop && rx_eop && rx_crc_ok &&
               ((state_q == ST_QNT) || (state_q == ST_TAIL));
        fire_qnt = (state_q == ST_QNT) ? rx_data[DATA_W-1:QNT_LSB] : qnt_q;
    end

    // State register and quanta capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            qnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (rx_valid && !rx_sop && (state_q == ST_QNT))
                qnt_q <= rx_data[DATA_W-1:QNT_LSB];
        end
    end

    // Report outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pause_valid  <= 1'b0;
            pause_quanta <= '0;
        end else begin
            pause_valid <= fire;
            if (fire)
                pause_quanta <= fire_qnt;
        end
    end

endmodule

// File: rtl/rx_pause_detect_chk.sv
module rx_pause_detect_chk #(
    parameter int QUANTA_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rx_valid,
    input logic                rx_eop,
    input logic                rx_crc_ok,
    input logic                pause_valid,
    input logic [QUANTA_W-1:0] pause_quanta
);

    // R3: a report lasts exactly one cycle.
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pause_valid |=> !pause_valid);

    // R8: a report follows a good end beat.
    assert_report_after_good_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pause_valid) |-> $past(rx_valid && rx_eop && rx_crc_ok));

    // R3: the quanta holds between reports.
    assert_quanta_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pause_valid |=> (pause_valid || $stable(pause_quanta)));

    // R10: an idle cycle never yields a report.
    assert_idle_no_report_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !pause_valid);

    // R1: the report stays low in the cycle after reset.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> !pause_valid);

endmodule

bind rx_pause_detect rx_pause_detect_chk #(.QUANTA_W(QUANTA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_eop       (rx_eop),
    .rx_crc_ok    (rx_crc_ok),
    .pause_valid  (pause_valid),
    .pause_quanta (pause_quanta)
);

// File: tb/rx_pause_detect_test.sv
module rx_pause_detect_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [47:0] MCAST = 48'h0180_C200_0001;
    localparam logic [47:0] STN   = 48'h0024_5A11_22C3;

    typedef struct {
        logic [15:0] q;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0, rx_crc_ok = 1'b0;
    logic [63:0] rx_data = '0;
    logic        cfg_rx_pause_en = 1'b1, cfg_ucast_en = 1'b0;
    logic [47:0] cfg_station_addr = STN;
    logic        pause_valid;
    logic [15:0] pause_quanta;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";
    exp_t  sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_pause_detect uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sop(rx_sop),
        .rx_eop(rx_eop), .rx_data(rx_data), .rx_crc_ok(rx_crc_ok),
        .cfg_rx_pause_en(cfg_rx_pause_en), .cfg_ucast_en(cfg_ucast_en),
        .cfg_station_addr(cfg_station_addr), .pause_valid(pause_valid),
        .pause_quanta(pause_quanta)
    );

    // Monitor: pops expected reports, flags unexpected ones and wide pulses.
    bit prev_pv = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (pause_valid) begin
                checks++;
                if (prev_pv) begin
                    errors++;
                    $display("FAIL R3 pulse wider than one cycle: actual 1 expected 0");
                end else if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL %s unexpected report: actual quanta %h expected none",
                             cur_tag, pause_quanta);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (pause_quanta !== e.q) begin
                        errors++;
                        $display("FAIL %s quanta: actual %h expected %h", e.tag, pause_quanta, e.q);
                    end
                end
            end
            prev_pv = pause_valid;
        end
    end

    task automatic beat(input logic [63:0] d, input logic s, input logic e, input logic crc);
        @(negedge clk);
        rx_valid = 1'b1; rx_sop = s; rx_eop = e; rx_data = d; rx_crc_ok = crc;
        @(negedge clk);
        rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_crc_ok = 1'b0;
        rx_data = 64'hDEAD_BEEF_0BAD_F00D;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: builds a frame of nb beats, pushes the expected report.
    task automatic frame(input logic [47:0] da, input logic [15:0] typ, input logic [15:0] op,
                         input logic [15:0] q, input int nb, input logic crc,
                         input bit gaps, input bit expect_rep, input string tag);
        logic [63:0] b;
        cur_tag = tag;
        if (expect_rep) begin
            exp_t e;
            e.q = q; e.tag = tag;
            sb.push_back(e);
        end
        for (int i = 0; i < nb; i++) begin
            case (i)
                0:       b = {da, 16'h5E10};
                1:       b = {32'h7733_4455, typ, op};
                2:       b = {q, 48'h0};
                default: b = 64'h0;
            endcase
            beat(b, i == 0, i == nb - 1, crc);
            if (gaps) idle(2);
        end
        idle(3);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL %s report missing: actual none expected quanta %h", tag, sb[0].q);
            sb.delete();
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (pause_valid !== 1'b0 || pause_quanta !== 16'h0) begin
            errors++;
            $display("FAIL R1 reset outputs: actual %b/%h expected 0/0000", pause_valid, pause_quanta);
        end

        frame(MCAST, 16'h8808, 16'h0001, 16'h1234, 8, 1, 0, 1, "R2 R4 multicast");
        // R3: the quanta holds after the pulse.
        idle(5);
        checks++;
        if (pause_valid !== 1'b0 || pause_quanta !== 16'h1234) begin
            errors++;
            $display("FAIL R3 hold: actual %b/%h expected 0/1234", pause_valid, pause_quanta);
        end

        frame(STN, 16'h8808, 16'h0001, 16'h00AB, 8, 1, 0, 0, "R5 unicast disabled");
        cfg_ucast_en = 1'b1;
        frame(STN, 16'h8808, 16'h0001, 16'h00AB, 8, 1, 0, 1, "R5 unicast enabled");
        frame(48'h0180_C200_0002, 16'h8808, 16'h0001, 16'h0042, 8, 1, 0, 0, "R4 foreign address");
        cfg_ucast_en = 1'b0;

        cfg_rx_pause_en = 1'b0;
        frame(MCAST, 16'h8808, 16'h0001, 16'h0777, 8, 1, 0, 0, "R6 disabled");
        cfg_rx_pause_en = 1'b1;

        frame(MCAST, 16'h0800, 16'h0001, 16'h0101, 8, 1, 0, 0, "R7 wrong type");
        frame(MCAST, 16'h8808, 16'h0101, 16'h0102, 8, 1, 0, 0, "R7 wrong opcode");
        frame(MCAST, 16'h8808, 16'h0001, 16'h0BAD, 8, 0, 0, 0, "R8 bad crc");

        frame(MCAST, 16'h8808, 16'h0001, 16'h0555, 2, 1, 0, 0, "R9 short frame");
        frame(MCAST, 16'h8808, 16'h0001, 16'hA5C3, 3, 1, 0, 1, "R9 ends on quanta beat");

        frame(MCAST, 16'h8808, 16'h0001, 16'hFEDC, 8, 1, 1, 1, "R10 gaps");

        // R11: an abandoned header is followed by a full frame.
        cur_tag = "R11 restart";
        beat({MCAST, 16'h5E10}, 1, 0, 1);
        beat({32'h7733_4455, 16'h8808, 16'h0001}, 0, 0, 1);
        frame(MCAST, 16'h8808, 16'h0001, 16'h3C3C, 8, 1, 0, 1, "R11 restart");

        frame(MCAST, 16'h8808, 16'h0001, 16'h0000, 8, 1, 0, 1, "R12 zero quanta");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule